// File: doc/BRIEF.md
# Configurable Synchronization Resource Column

This block manages one shared synchronization primitive for a grid of lock nodes. One standard port serves every primitive type. A processor drives a resource address, a 16-bit write-data bus and a set of single-cycle command strobes. The block keeps the primitive's state: a count, a flag word with an enable mask, a pending-interrupt latch or a countdown timer. From that state and from its device inputs it computes `free_out`, which tells the node chain that a lock may be granted now.

The node chain reports back in two ways. `in_use` is high while any node holds a grant on this resource. `took_grant` pulses for one cycle each time a node takes a grant. The block reacts to strobes only when `res_addr` equals its `RES_ID` parameter.

The primitive type comes from the 3-bit `mode_sel` strap. The data flow is single-cycle strobes and combinational status, so no port carries a valid/ready handshake. A read strobe returns data in the same cycle, and command strobes take effect at the next rising clock edge.

Top module: `sync_res_col`

## Requirements
- R1: Strobes take effect only when `res_addr` equals `RES_ID`. With any other address they change no state, and `rd_data` stays 0 whenever no matching read strobe is present.
- R2: Mode 0 (mutex): `free_out` equals the inverse of `in_use`.
- R3: Mode 1 (semaphore): a write loads the count from `wr_data`, and `free_out` is high while the count is at least 1. Each `took_grant` lowers the count by one, and the count stops at 0.
- R4: Mode 1 same-cycle rules. A release raises the count by one, stopping at 0xFFFF. A release and a grant in the same cycle leave the count unchanged. A write in the same cycle as a grant loads `wr_data` minus one, or 0 if `wr_data` is 0.
- R5: Modes 2 and 3 (events): each cycle, bits of `evt_in` are set into the flag word. A sig1 strobe sets the flag bits given in `wr_data`, and a sig2 strobe clears them, but a bit being set in the same cycle stays set. An enable strobe ORs `wr_data` into the mask, and a disable strobe clears the mask bits given in `wr_data`.
- R6: In mode 2, `free_out` is high when the mask is non-zero and every masked flag is set. In mode 3, `free_out` is high when any masked flag is set.
- R7: Mode 4 (interrupt): an `irq_in` pulse sets a pending latch, and `free_out` follows the latch. A `took_grant` clears the latch, unless `irq_in` is high in that same cycle, in which case the latch stays set.
- R8: Mode 5 (queue reader): `free_out` is high when `q_empty` and `in_use` are both low. Mode 6 (queue writer): `free_out` is high when `q_full` and `in_use` are both low.
- R9: Mode 7 (timer): a write loads the timer. The timer decrements once every `TICK_DIV` clocks and stays at 0 once it gets there. `free_out` is high while the timer is 0. A write in the same cycle as a tick loads `wr_data` and skips the decrement.
- R10: A matching read strobe puts data on `rd_data` in the same cycle: the count, flags or timer in modes 1, 2, 3 and 7; the pending latch in bit 0 in mode 4; `in_use` in bit 0 in modes 0, 5 and 6.
- R11: A matching reset strobe, or `rst_n` low, clears the count, flags, mask, timer, pending latch and tick prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Primitive type strap (0..7, see R2-R9) |
| res_addr | input | ADDR_W | Resource address of the current command |
| wr_data | input | DATA_W | Write data for write, enable, disable, sig1 and sig2 strobes |
| rd_data | output | DATA_W | Read data, valid in the cycle of a matching read strobe |
| en_stb | input | 1 | Enable strobe (sets event mask bits) |
| dis_stb | input | 1 | Disable strobe (clears event mask bits) |
| sig1_stb | input | 1 | Signal-one strobe (sets event flags) |
| sig2_stb | input | 1 | Signal-two strobe (clears event flags) |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe (count or timer load) |
| rst_stb | input | 1 | Resource reset strobe |
| rel_stb | input | 1 | Release strobe |
| took_grant | input | 1 | Pulse from the node chain when a grant is taken |
| in_use | input | 1 | Some node holds a grant on this resource |
| q_empty | input | 1 | Attached queue is empty |
| q_full | input | 1 | Attached queue is full |
| irq_in | input | 1 | Interrupt event pulse |
| evt_in | input | DATA_W | Event flag set inputs |
| free_out | output | 1 | Resource may be granted now |

## Verification
The risky cases are two updates that land on the same state register in one cycle. These are a semaphore release or write together with a grant pulse, an interrupt pulse together with the grant that consumes the latch, an event sig2 clear together with an incoming flag, and a timer write on the prescaler's tick cycle. The bench drives these pairs on purpose, including one write placed to land exactly on a tick. A behavioural model updates with the priorities stated in the requirements, and the bench compares `free_out` and `rd_data` with that model on every clock.

// File: rtl/res_pkg.sv
package res_pkg;
  typedef enum logic [2:0] {
    RM_MUTEX  = 3'd0,
    RM_SEM    = 3'd1,
    RM_EV_ALL = 3'd2,
    RM_EV_ANY = 3'd3,
    RM_IRQ    = 3'd4,
    RM_RDGATE = 3'd5,
    RM_WRGATE = 3'd6,
    RM_TIMER  = 3'd7
  } res_mode_e;
endpackage

// File: rtl/res_tick_gen.sv
module res_tick_gen #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/res_state.sv
module res_state
  import res_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  res_mode_e     mode,
  input  logic          hit_wr,
  input  logic          hit_rel,
  input  logic          hit_rst,
  input  logic          hit_en,
  input  logic          hit_dis,
  input  logic          hit_set,
  input  logic          hit_clr,
  input  logic [DW-1:0] wdata,
  input  logic          took_grant,
  input  logic [DW-1:0] evt_in,
  input  logic          irq_in,
  input  logic          tick,
  output logic [DW-1:0] val,
  output logic [DW-1:0] mask,
  output logic          pend
);
  localparam logic [DW-1:0] VMAX = '1;
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic [DW-1:0] val_d, mask_d;
  logic          pend_d;

  always_comb begin
    val_d  = val;
    pend_d = pend;
    mask_d = (mask | (hit_en ? wdata : '0)) & ~(hit_dis ? wdata : '0);
    unique case (mode)
      RM_SEM: begin
        if (hit_wr)
          val_d = (took_grant && wdata != '0) ? wdata - ONE : wdata;
        else if (hit_rel && took_grant)
          val_d = val;
        else if (hit_rel)
          val_d = (val == VMAX) ? VMAX : val + ONE;
        else if (took_grant)
          val_d = (val == '0) ? '0 : val - ONE;
      end
      RM_EV_ALL, RM_EV_ANY:
        val_d = (val & ~(hit_clr ? wdata : '0)) | evt_in | (hit_set ? wdata : '0);
      RM_IRQ:
        pend_d = irq_in | (pend & ~took_grant);
      RM_TIMER: begin
        if (hit_wr)                   val_d = wdata;
        else if (tick && val != '0)   val_d = val - ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hit_rst) begin
      val  <= '0;
      mask <= '0;
      pend <= 1'b0;
    end else begin
      val  <= val_d;
      mask <= mask_d;
      pend <= pend_d;
    end
  end

  // R3
  sem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_SEM && took_grant && !hit_wr && !hit_rel && !hit_rst && val != '0)
    |=> (val == $past(val) - ONE));

  // R9
  timer_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_TIMER && val == '0 && !hit_wr) |=> (val == '0));

  // R7
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_IRQ && irq_in && !hit_rst) |=> pend);

  // R5
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == RM_EV_ALL || mode == RM_EV_ANY) && !hit_rst)
    |=> (($past(evt_in) & ~val) == '0));

  // R11
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rst |=> (val == '0 && mask == '0 && !pend));
endmodule

// File: rtl/res_free_eval.sv
module res_free_eval
  import res_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  res_mode_e     mode,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] mask,
  input  logic          pend,
  input  logic          in_use,
  input  logic          q_empty,
  input  logic          q_full,
  output logic          free
);
  always_comb begin
    unique case (mode)
      RM_MUTEX:  free = !in_use;
      RM_SEM:    free = (val != '0);
      RM_EV_ALL: free = (mask != '0) && ((val & mask) == mask);
      RM_EV_ANY: free = |(val & mask);
      RM_IRQ:    free = pend;
      RM_RDGATE: free = !q_empty && !in_use;
      RM_WRGATE: free = !q_full && !in_use;
      RM_TIMER:  free = (val == '0);
      default:   free = 1'b0;
    endcase
  end
endmodule

// File: rtl/sync_res_col.sv
module sync_res_col
  import res_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned RES_ID   = 1,
  parameter int unsigned TICK_DIV = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              en_stb,
  input  logic              dis_stb,
  input  logic              sig1_stb,
  input  logic              sig2_stb,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              rst_stb,
  input  logic              rel_stb,
  input  logic              took_grant,
  input  logic              in_use,
  input  logic              q_empty,
  input  logic              q_full,
  input  logic              irq_in,
  input  logic [DATA_W-1:0] evt_in,
  output logic              free_out
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(RES_ID);

  res_mode_e         mode;
  logic              hit, tick, pend;
  logic [DATA_W-1:0] val, mask;

  assign mode = res_mode_e'(mode_sel);
  assign hit  = (res_addr == MY_ADDR);

  res_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(hit && rst_stb), .tick(tick)
  );

  res_state #(.DW(DATA_W)) u_state (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .hit_wr(hit && wr_stb), .hit_rel(hit && rel_stb), .hit_rst(hit && rst_stb),
    .hit_en(hit && en_stb), .hit_dis(hit && dis_stb),
    .hit_set(hit && sig1_stb), .hit_clr(hit && sig2_stb),
    .wdata(wr_data), .took_grant(took_grant), .evt_in(evt_in),
    .irq_in(irq_in), .tick(tick), .val(val), .mask(mask), .pend(pend)
  );

  res_free_eval #(.DW(DATA_W)) u_free (
    .mode(mode), .val(val), .mask(mask), .pend(pend), .in_use(in_use),
    .q_empty(q_empty), .q_full(q_full), .free(free_out)
  );

  always_comb begin
    rd_data = '0;
    if (hit && rd_stb) begin
      unique case (mode)
        RM_SEM, RM_EV_ALL, RM_EV_ANY, RM_TIMER: rd_data = val;
        RM_IRQ:  rd_data = {{(DATA_W-1){1'b0}}, pend};
        default: rd_data = {{(DATA_W-1){1'b0}}, in_use};
      endcase
    end
  end

  // R2
  mutex_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_MUTEX && in_use) |-> !free_out);

  // R1
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |-> (rd_data == '0));
endmodule

// File: tb/sim_sync_res_col.sv
module sim_sync_res_col;
  localparam int ID  = 42;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [7:0]  res_addr = 8'(ID);
  logic [15:0] wr_data = '0, evt_in = '0;
  logic [15:0] rd_data;
  logic en_stb = 0, dis_stb = 0, sig1_stb = 0, sig2_stb = 0, rd_stb = 0;
  logic wr_stb = 0, rst_stb = 0, rel_stb = 0, took_grant = 0, in_use = 0;
  logic q_empty = 1, q_full = 0, irq_in = 0;
  logic free_out;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R11";

  // behavioural model state
  logic [15:0] m_val = '0, m_mask = '0;
  logic        m_pend = 0;
  int          m_pcnt = 0;

  always #4 clk = ~clk;

  sync_res_col #(.ADDR_W(8), .DATA_W(16), .RES_ID(ID), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .res_addr(res_addr),
    .wr_data(wr_data), .rd_data(rd_data), .en_stb(en_stb), .dis_stb(dis_stb),
    .sig1_stb(sig1_stb), .sig2_stb(sig2_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rst_stb(rst_stb), .rel_stb(rel_stb), .took_grant(took_grant), .in_use(in_use),
    .q_empty(q_empty), .q_full(q_full), .irq_in(irq_in), .evt_in(evt_in),
    .free_out(free_out)
  );

  function automatic logic exp_free();
    case (mode_sel)
      3'd0: return !in_use;
      3'd1: return m_val != 0;
      3'd2: return (m_mask != 0) && ((m_val & m_mask) == m_mask);
      3'd3: return (m_val & m_mask) != 0;
      3'd4: return m_pend;
      3'd5: return !q_empty && !in_use;
      3'd6: return !q_full && !in_use;
      default: return m_val == 0;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd();
    if (!(res_addr == 8'(ID) && rd_stb)) return 16'h0;
    case (mode_sel)
      3'd1, 3'd2, 3'd3, 3'd7: return m_val;
      3'd4: return {15'h0, m_pend};
      default: return {15'h0, in_use};
    endcase
  endfunction

  task automatic model_step();
    bit hit = (res_addr == 8'(ID));
    bit tick = (m_pcnt == DIV - 1);
    logic [15:0] v = m_val;
    if (!rst_n || (hit && rst_stb)) begin
      m_val = 0; m_mask = 0; m_pend = 0; m_pcnt = 0;
      return;
    end
    m_pcnt = tick ? 0 : m_pcnt + 1;
    m_mask = (m_mask | ((hit && en_stb) ? wr_data : 16'h0)) & ~((hit && dis_stb) ? wr_data : 16'h0);
    case (mode_sel)
      3'd1: begin
        if (hit && wr_stb) m_val = (took_grant && wr_data != 0) ? wr_data - 1 : wr_data;
        else if (hit && rel_stb && took_grant) m_val = v;
        else if (hit && rel_stb) m_val = (v == 16'hFFFF) ? v : v + 1;
        else if (took_grant) m_val = (v == 0) ? 16'h0 : v - 1;
      end
      3'd2, 3'd3:
        m_val = (v & ~((hit && sig2_stb) ? wr_data : 16'h0)) | evt_in | ((hit && sig1_stb) ? wr_data : 16'h0);
      3'd4: m_pend = irq_in || (m_pend && !took_grant);
      3'd7: begin
        if (hit && wr_stb) m_val = wr_data;
        else if (tick && v != 0) m_val = v - 1;
      end
      default: ;
    endcase
  endtask

  task automatic cyc();
    logic ef;
    logic [15:0] er;
    #2;
    ef = exp_free();
    er = exp_rd();
    checks++;
    if (free_out !== ef) begin
      errors++;
      $display("FAIL %s free_out mode %0d: actual %b expected %b", req, mode_sel, free_out, ef);
    end
    checks++;
    if (rd_data !== er) begin
      errors++;
      $display("FAIL %s rd_data mode %0d: actual %h expected %h", req, mode_sel, rd_data, er);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    {en_stb, dis_stb, sig1_stb, sig2_stb, rd_stb, wr_stb, rst_stb, rel_stb} = '0;
    took_grant = 0; irq_in = 0; evt_in = '0; res_addr = 8'(ID);
  endtask

  task automatic go(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic fresh(logic [2:0] m);
    mode_sel = m; rst_stb = 1; cyc();
  endtask

  initial begin
    @(negedge clk);
    req = "R11"; go(3);
    rst_n = 1; go(2);

    req = "R2"; mode_sel = 0;
    in_use = 1; go(2); in_use = 0; go(1); in_use = 1; rd_stb = 1; cyc(); in_use = 0;

    req = "R3"; fresh(1);
    wr_stb = 1; wr_data = 3; cyc();
    for (int i = 0; i < 4; i++) begin took_grant = 1; rd_stb = 1; cyc(); end
    rd_stb = 1; cyc();

    req = "R4";
    wr_stb = 1; wr_data = 2; cyc();
    rel_stb = 1; took_grant = 1; rd_stb = 1; cyc();
    rel_stb = 1; rd_stb = 1; cyc();
    wr_stb = 1; wr_data = 5; took_grant = 1; cyc();
    rd_stb = 1; cyc();
    wr_stb = 1; wr_data = 0; took_grant = 1; cyc();
    wr_stb = 1; wr_data = 16'hFFFF; cyc();
    rel_stb = 1; rd_stb = 1; cyc();

    req = "R1";
    res_addr = 8'(ID + 1); wr_stb = 1; wr_data = 9; cyc();
    res_addr = 8'(ID + 1); rd_stb = 1; cyc();
    res_addr = 8'(ID + 1); rst_stb = 1; cyc();
    rd_stb = 1; cyc();

    req = "R5"; fresh(2);
    en_stb = 1; wr_data = 16'h0003; cyc();
    evt_in = 16'h0001; cyc();
    rd_stb = 1; cyc();
    req = "R6"; evt_in = 16'h0002; cyc();
    rd_stb = 1; cyc();
    req = "R5"; sig2_stb = 1; wr_data = 16'h0003; evt_in = 16'h0001; cyc();
    rd_stb = 1; cyc();
    sig1_stb = 1; wr_data = 16'h0100; cyc();
    req = "R6"; mode_sel = 3; go(2);
    dis_stb = 1; wr_data = 16'h0001; cyc();
    go(1);
    en_stb = 1; wr_data = 16'h0100; cyc();
    mode_sel = 2; go(1);

    req = "R7"; fresh(4);
    go(1);
    irq_in = 1; cyc();
    rd_stb = 1; cyc();
    took_grant = 1; cyc();
    go(1);
    irq_in = 1; cyc();
    took_grant = 1; irq_in = 1; cyc();
    rd_stb = 1; cyc();
    took_grant = 1; cyc();
    rel_stb = 1; rd_stb = 1; cyc();

    req = "R8"; fresh(5);
    q_empty = 1; go(1); q_empty = 0; go(1); in_use = 1; rd_stb = 1; go(1); in_use = 0;
    mode_sel = 6; q_full = 0; go(1); q_full = 1; go(1); q_full = 0; in_use = 1; go(1); in_use = 0; go(1);

    req = "R9"; fresh(7);
    wr_stb = 1; wr_data = 3; cyc();
    for (int i = 0; i < 18; i++) begin rd_stb = 1; cyc(); end
    wr_stb = 1; wr_data = 2; cyc();
    go(2);
    wr_stb = 1; wr_data = 6; cyc();
    for (int i = 0; i < 6; i++) begin rd_stb = 1; cyc(); end
    req = "R11"; rst_stb = 1; cyc();
    rd_stb = 1; cyc();
    go(5);

    req = "R10"; fresh(4); irq_in = 1; cyc(); rd_stb = 1; cyc();
    mode_sel = 0; in_use = 1; rd_stb = 1; cyc(); in_use = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog expired: actual running expected finished", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule